// File: doc/BRIEF.md
# Next-PC and Instruction Fetch Unit

This unit owns the program counter of a simple processor core. Each cycle it presents the current PC, the PC advanced by one word, and the instruction word read from an on-chip instruction ROM at that PC. It also picks the address for the following cycle: the next word in sequence, a PC-relative branch target, or a region-relative jump target. The choice depends on three control inputs that the decode logic and the ALU would normally drive.

The branch target adds the instruction's low 16-bit field to PC+4, after sign extension and a scale to words. The jump target keeps the top four bits of PC+4 and fills the rest from the instruction's low 26 bits, scaled to words. A jump takes precedence over a branch. The ROM contents are generated from a fixed formula, so the block needs no load path. It is read combinationally in the cycle in which the PC is valid.

Top module: `fetch_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC loads 0 (parameter `RESET_PC`) at that edge.
- R2: `pc_plus4_o` always equals `pc_o + 4` modulo 2^32.
- R3: `instr_o` equals the ROM word at index `pc_o[ADDR_W+1:2]`, read in the same cycle. ROM word i is the bitwise inverse of (i * 0x9E3779B9) modulo 2^32, and the PC bits above the index are ignored.
- R4: With `jump_i` low and `branch_i` low, the PC becomes `pc_plus4_o` at the next rising edge.
- R5: With `branch_i` and `zero_i` both high and `jump_i` low, the next PC is `pc_plus4_o` plus `instr_o[15:0]` sign-extended from bit 15 and multiplied by 4.
- R6: With `jump_i` low and only one of `branch_i` and `zero_i` high, the next PC is `pc_plus4_o`.
- R7: With `jump_i` high, the next PC is {`pc_plus4_o[31:28]`, `instr_o[25:0]`, 2'b00}, whatever `branch_i` and `zero_i` are.
- R8: A taken branch whose displacement field is 0xFFFF gives a next PC equal to the current PC (PC + 4 - 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| branch_i | input | 1 | Instruction is a conditional branch |
| jump_i | input | 1 | Instruction is an unconditional jump |
| zero_i | input | 1 | ALU result-is-zero flag |
| instr_o | output | 32 | Instruction word at the current PC |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current PC plus 4 |

## Verification
`instr_o` and `pc_plus4_o` follow `pc_o` within the same cycle. A change on `branch_i`, `jump_i`, `zero_i` or `rst_n` shows up on `pc_o` after exactly one rising edge. The bench therefore drives new controls on the falling edge. At the next falling edge it compares all three outputs against a behavioural model of the PC, which it advances once per cycle from the controls that were applied. Each PC comparison is tagged with the requirement for the kind of step that produced it, including the self-loop taken branch at address 0.

// File: rtl/fetch_pkg.sv
// fetch_pkg: shared widths and the instruction ROM content formula.
// Assumes a 32-bit word-aligned address space.
package fetch_pkg;
    localparam int XLEN    = 32;
    localparam int OFF_W   = 16;   // branch displacement field width
    localparam int JIDX_W  = 26;   // jump index field width
    localparam int REGION_W = XLEN - JIDX_W - 2;  // upper PC bits kept on jump
    localparam logic [XLEN-1:0] ROM_MULT = 32'h9E37_79B9;

    typedef logic [XLEN-1:0] word_t;

    // ROM word for a given index: inverse of a multiplicative hash
    function automatic word_t rom_word(input int unsigned idx);
        word_t prod;
        prod = word_t'(idx) * ROM_MULT;
        return ~prod;
    endfunction
endpackage

// File: rtl/fetch_rom.sv
// fetch_rom: combinational instruction ROM of 2**ADDR_W words.
// Contents are computed at elaboration from fetch_pkg::rom_word.
// Assumes the caller supplies a word index, not a byte address.
module fetch_rom
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] idx_i,
    output word_t             data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t rom_q [DEPTH];

    // one constant word per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign rom_q[g] = rom_word(g);
    end

    assign data_o = rom_q[idx_i];
endmodule

// File: rtl/fetch_targets.sv
// fetch_targets: computes the sequential, branch and jump candidate
// addresses from the current PC and instruction. Purely combinational.
// Assumes word-aligned PC; scaling by 4 is wiring only.
module fetch_targets
    import fetch_pkg::*;
(
    input  word_t pc_i,
    input  word_t instr_i,
    output word_t seq_o,
    output word_t br_o,
    output word_t jmp_o
);
    logic [OFF_W-1:0]  disp;
    logic [JIDX_W-1:0] jidx;
    word_t             disp_scaled;

    assign disp = instr_i[OFF_W-1:0];
    assign jidx = instr_i[JIDX_W-1:0];

    // dedicated incrementer for the sequential address
    assign seq_o = pc_i + word_t'(4);

    // sign extension and word scaling by appending two zero bits
    assign disp_scaled = {{(XLEN-OFF_W-2){disp[OFF_W-1]}}, disp, 2'b00};

    // branch target adder works from the incremented PC
    assign br_o = seq_o + disp_scaled;

    // jump target keeps the region bits of PC+4
    assign jmp_o = {seq_o[XLEN-1 -: REGION_W], jidx, 2'b00};
endmodule

// File: rtl/fetch_next_sel.sv
// fetch_next_sel: two-level next-PC select. The first level chooses
// branch target or sequential from branch AND zero; the second lets a
// jump override both. Purely combinational.
module fetch_next_sel
    import fetch_pkg::*;
(
    input  logic  branch_i,
    input  logic  zero_i,
    input  logic  jump_i,
    input  word_t seq_i,
    input  word_t br_i,
    input  word_t jmp_i,
    output word_t next_o
);
    logic  take_br;
    word_t lvl1;

    assign take_br = branch_i & zero_i;

    // first level: branch target versus fall-through
    always_comb lvl1 = take_br ? br_i : seq_i;

    // second level: jump overrides
    always_comb next_o = jump_i ? jmp_i : lvl1;
endmodule

// File: rtl/fetch_pc_reg.sv
// fetch_pc_reg: program counter register, loaded every rising edge.
// Synchronous active-low reset to RESET_PC.
module fetch_pc_reg
    import fetch_pkg::*;
#(
    parameter word_t RESET_PC = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  word_t next_i,
    output word_t pc_o
);
    // PC update, no enable
    always_ff @(posedge clk) begin
        if (!rst_n) pc_o <= RESET_PC;
        else        pc_o <= next_i;
    end
endmodule

// File: rtl/fetch_unit.sv
// fetch_unit: top of the next-PC and instruction fetch logic.
// Holds the PC, reads the ROM at the PC and chooses the next PC from
// the branch, zero and jump controls. Assumes controls are stable
// before each rising edge.
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int    ADDR_W   = 6,
    parameter word_t RESET_PC = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        branch_i,
    input  logic        jump_i,
    input  logic        zero_i,
    output logic [31:0] instr_o,
    output logic [31:0] pc_o,
    output logic [31:0] pc_plus4_o
);
    word_t pc_q, instr_w, seq_w, br_w, jmp_w, next_w;

    fetch_pc_reg #(.RESET_PC(RESET_PC)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .next_i (next_w),
        .pc_o   (pc_q)
    );

    fetch_rom #(.ADDR_W(ADDR_W)) u_rom (
        .idx_i  (pc_q[ADDR_W+1:2]),
        .data_o (instr_w)
    );

    fetch_targets u_tgt (
        .pc_i    (pc_q),
        .instr_i (instr_w),
        .seq_o   (seq_w),
        .br_o    (br_w),
        .jmp_o   (jmp_w)
    );

    fetch_next_sel u_sel (
        .branch_i (branch_i),
        .zero_i   (zero_i),
        .jump_i   (jump_i),
        .seq_i    (seq_w),
        .br_i     (br_w),
        .jmp_i    (jmp_w),
        .next_o   (next_w)
    );

    assign pc_o       = pc_q;
    assign instr_o    = instr_w;
    assign pc_plus4_o = seq_w;
endmodule

// File: rtl/fetch_unit_chk.sv
// fetch_unit_chk: temporal checks on the fetch unit ports, bound to
// every fetch_unit instance.
module fetch_unit_chk #(
    parameter logic [31:0] RESET_PC = '0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        branch_i,
    input logic        jump_i,
    input logic        zero_i,
    input logic [31:0] instr_o,
    input logic [31:0] pc_o,
    input logic [31:0] pc_plus4_o
);
    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |=> pc_o == RESET_PC);

    assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_plus4_o == pc_o + 32'd4);

    assert_seq_R4_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_i && !(branch_i && zero_i)) |=> pc_o == $past(pc_plus4_o));

    assert_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_i && zero_i && !jump_i) |=>
        pc_o == $past(pc_plus4_o)
              + {{14{$past(instr_o[15])}}, $past(instr_o[15:0]), 2'b00});

    assert_self_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_i && zero_i && !jump_i && instr_o[15:0] == 16'hFFFF) |=>
        $stable(pc_o));

    assert_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i |=> pc_o == {$past(pc_plus4_o[31:28]), $past(instr_o[25:0]), 2'b00});
endmodule

bind fetch_unit fetch_unit_chk #(.RESET_PC(RESET_PC)) u_fetch_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .branch_i   (branch_i),
    .jump_i     (jump_i),
    .zero_i     (zero_i),
    .instr_o    (instr_o),
    .pc_o       (pc_o),
    .pc_plus4_o (pc_plus4_o)
);

// File: tb/test_fetch_unit.sv
// test_fetch_unit: behavioural PC model compared against the outputs
// every cycle. Inputs change and outputs are sampled on falling edges.
module test_fetch_unit;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        branch_i = 1'b0;
    logic        jump_i = 1'b0;
    logic        zero_i = 1'b0;
    logic [31:0] instr_o, pc_o, pc_plus4_o;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    fetch_unit #(.ADDR_W(AW), .RESET_PC(32'h0)) i_fetch_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .branch_i   (branch_i),
        .jump_i     (jump_i),
        .zero_i     (zero_i),
        .instr_o    (instr_o),
        .pc_o       (pc_o),
        .pc_plus4_o (pc_plus4_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    // ROM content as stated in R3
    function automatic logic [31:0] model_word(input logic [31:0] pc);
        int unsigned idx;
        idx = int'(pc[AW+1:2]);
        return ~(idx * 32'h9E37_79B9);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] exp_pc;
    string       tag;

    // apply one cycle of controls, then advance the model
    task automatic step(input logic r, input logic b, input logic z, input logic j);
        logic [31:0] w, p4;
        rst_n = r; branch_i = b; zero_i = z; jump_i = j;
        w  = model_word(exp_pc);
        p4 = exp_pc + 32'd4;
        if (!r) begin
            exp_pc = 32'h0; tag = "R1";
        end else if (j) begin
            exp_pc = {p4[31:28], w[25:0], 2'b00}; tag = "R7";
        end else if (b && z) begin
            exp_pc = p4 + {{14{w[15]}}, w[15:0], 2'b00};
            tag = (w[15:0] == 16'hFFFF) ? "R8" : "R5";
        end else if (b || z) begin
            exp_pc = p4; tag = "R6";
        end else begin
            exp_pc = p4; tag = "R4";
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, pc_o, exp_pc);
        check("R2", pc_plus4_o, exp_pc + 32'd4);
        check("R3", instr_o, model_word(exp_pc));
    endtask

    initial begin
        exp_pc = 32'h0;
        tag = "R1";
        @(negedge clk);
        // reset for a few edges
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        // R8: word 0 has displacement 0xFFFF, so a taken branch self-loops
        step(1'b1, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b0);
        // R4: straight-line run across the ROM wrap
        for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        // R6: single-sided controls
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        // R7: jump beats a taken branch
        step(1'b1, 1'b1, 1'b1, 1'b1);
        // mixed traffic with a mid-run reset (R1)
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 9);
            if (i == 1500 || i == 1501)
                step(1'b0, 1'b1, 1'b1, 1'b1);
            else if (r < 2)
                step(1'b1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1);
            else if (r < 4)
                step(1'b1, 1'b1, 1'b1, 1'b0);
            else if (r == 4)
                step(1'b1, 1'b1, 1'b0, 1'b0);
            else if (r == 5)
                step(1'b1, 1'b0, 1'b1, 1'b0);
            else
                step(1'b1, 1'b0, 1'b0, 1'b0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule